// File: doc/BRIEF.md
# Debug Port Lock Controller

This block decides whether the chip's JTAG / serial-wire debug port may be used. When reset is released, it fetches one word from a reserved location in user flash. It compares that word with a fixed lock key. If the word equals the key, debug starts locked. Any other value leaves debug open. Until the fetched word has been judged, the debug-enable output stays low and the readiness bit reads 0.

Once the decision is made, application software can open or close the port by writing a single control register over a simple write-strobe register bus. The register reads back, at all times, the enable state, whether the flash word matched the key, and whether the decision is ready. The key is judged once per reset. Flash activity after that point has no effect.

Top module: `dbg_lock_ctrl`

## Requirements
- R1: While reset is asserted and until the flash word arrives, `dbgEnable` is 0, `flashReq` is 1, `flashAddr` is byte address 0x5FFE8, and the readiness bit reads 0.
- R2: If the word sampled with `flashValid` high equals 0x16032010, then from the following cycle the readiness bit is 1, the match bit is 1 and `dbgEnable` is 0.
- R3: If the sampled word differs from 0x16032010, then from the following cycle the readiness bit is 1, the match bit is 0 and `dbgEnable` is 1.
- R4: `flashReq` stays high until `flashValid` is sampled. It then falls in the next cycle and stays low until the next reset.
- R5: Once ready, a cycle with `regWr` high sets `dbgEnable` to `regWdata[0]` in the following cycle. Without a write, `dbgEnable` holds its value.
- R6: Register writes made before the readiness bit is 1 have no effect on `dbgEnable` or on the result of the key check.
- R7: `regRdata` bit 0 is the enable state, bit 1 is the key-match result, bit 2 is the readiness bit, and all higher bits read 0.
- R8: After the decision, further `flashValid` pulses with any data leave the match bit and `dbgEnable` unchanged.
- R9: `dbgEnable` is never 1 while the readiness bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flashReq | output | 1 | Request to read the lock word from flash |
| flashAddr | output | 20 | Byte address of the lock word |
| flashValid | input | 1 | Flash returns read data this cycle |
| flashRdata | input | 32 | Flash read data |
| regWr | input | 1 | Control register write strobe |
| regWdata | input | 32 | Control register write data |
| regRdata | output | 32 | Control register read value |
| dbgEnable | output | 1 | Gate for the debug port (1 = usable) |

## Verification
The assertions assume that `flashValid` is a single-cycle pulse whose data is valid in the same cycle. They also assume that the register bus changes only between clock edges. The bench drives every input on the falling edge. It lets the flash answer after a random delay of zero to several cycles, and it chooses the returned word as the key, a random value, or a value one bit away from the key. While the request is pending, it issues random writes to show that they are ignored. After the decision, it sends stray flash pulses to show that they are ignored too.

// File: rtl/dbg_lock_pkg.sv
package dbg_lock_pkg;

  typedef struct packed {
    logic loadKey;   // flash word is being judged this cycle
    logic regWrite;  // accepted control register write
  } ctrlStrobes_t;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_RUN   = 1'b1
  } lockState_e;

endpackage

// File: rtl/dbg_lock_fsm.sv
module dbg_lock_fsm
  import dbg_lock_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         flashValid,
  input  logic         regWr,
  output logic         flashReq,
  output logic         ready,
  output ctrlStrobes_t strobes
);

  lockState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    if (stateQ == ST_FETCH && flashValid) stateD = ST_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_FETCH;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobes.loadKey  = (stateQ == ST_FETCH) && flashValid;
    strobes.regWrite = (stateQ == ST_RUN) && regWr;
  end

  assign flashReq = (stateQ == ST_FETCH);
  assign ready    = (stateQ == ST_RUN);

endmodule

// File: rtl/dbg_lock_dp.sv
module dbg_lock_dp
  import dbg_lock_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] LOCK_KEY = 32'h1603_2010
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              ready,
  input  logic [DATA_W-1:0] flashRdata,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              dbgEnable
);

  localparam int STATUS_W = 3;
  localparam logic [DATA_W-1:0] KEY_EXT = DATA_W'(LOCK_KEY);

  logic enQ;
  logic matchQ;
  logic keyHit;

  assign keyHit = (flashRdata == KEY_EXT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      matchQ <= 1'b0;
    end else if (strobes.loadKey) begin
      matchQ <= keyHit;
      enQ    <= !keyHit;
    end else if (strobes.regWrite) begin
      enQ    <= regWdata[0];
    end
  end

  always_comb begin
    regRdata = '0;
    regRdata[STATUS_W-1:0] = {ready, matchQ, enQ};
  end

  assign dbgEnable = enQ;

endmodule

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl
  import dbg_lock_pkg::*;
#(
  parameter int          ADDR_W   = 20,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] LOCK_KEY = 32'h1603_2010,
  parameter logic [31:0] KEY_ADDR = 32'h0005_FFE8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              flashReq,
  output logic [ADDR_W-1:0] flashAddr,
  input  logic              flashValid,
  input  logic [DATA_W-1:0] flashRdata,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              dbgEnable
);

  ctrlStrobes_t strobes;
  logic         ready;

  assign flashAddr = ADDR_W'(KEY_ADDR);

  dbg_lock_fsm uFsm (
    .clk(clk), .rstN(rstN), .flashValid(flashValid), .regWr(regWr),
    .flashReq(flashReq), .ready(ready), .strobes(strobes)
  );

  dbg_lock_dp #(.DATA_W(DATA_W), .LOCK_KEY(LOCK_KEY)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ready(ready),
    .flashRdata(flashRdata), .regWdata(regWdata),
    .regRdata(regRdata), .dbgEnable(dbgEnable)
  );

endmodule

// File: rtl/dbg_lock_sva.sv
module dbg_lock_sva #(
  parameter int          ADDR_W   = 20,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] LOCK_KEY = 32'h1603_2010,
  parameter logic [31:0] KEY_ADDR = 32'h0005_FFE8
) (
  input logic              clk,
  input logic              rstN,
  input logic              flashReq,
  input logic [ADDR_W-1:0] flashAddr,
  input logic              flashValid,
  input logic [DATA_W-1:0] flashRdata,
  input logic              regWr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              dbgEnable
);

  logic rdy;
  logic mat;
  assign rdy = regRdata[2];
  assign mat = regRdata[1];

  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    flashReq |-> flashAddr == ADDR_W'(KEY_ADDR) && !rdy);  // R1
  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    flashReq && flashValid |=> rdy && (mat == ($past(flashRdata) == DATA_W'(LOCK_KEY)))
                               && (dbgEnable == !mat));  // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    flashReq && !flashValid |=> flashReq);  // R4
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !flashReq |=> !flashReq);  // R4
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    rdy && regWr |=> dbgEnable == $past(regWdata[0]));  // R5
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    rdy && !regWr |=> $stable(dbgEnable));  // R5
  AST_READ_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:3] == '0 && regRdata[0] == dbgEnable);  // R7
  AST_MATCH_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    rdy |=> rdy && $stable(mat));  // R8
  AST_EN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    !rdy |-> !dbgEnable);  // R9

endmodule

bind dbg_lock_ctrl dbg_lock_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_KEY(LOCK_KEY), .KEY_ADDR(KEY_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .flashReq(flashReq), .flashAddr(flashAddr),
  .flashValid(flashValid), .flashRdata(flashRdata), .regWr(regWr),
  .regWdata(regWdata), .regRdata(regRdata), .dbgEnable(dbgEnable)
);

// File: tb/dbg_lock_ctrl_test.sv
module dbg_lock_ctrl_test;

  localparam logic [31:0] KEY  = 32'h1603_2010;
  localparam logic [19:0] ADDR = 20'h5FFE8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flashReq;
  logic [19:0] flashAddr;
  logic        flashValid = 1'b0;
  logic [31:0] flashRdata = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        dbgEnable;

  int nTests = 0;
  int nFail  = 0;
  logic modelEn;
  logic modelMatch;

  always #10 clk = ~clk;

  dbg_lock_ctrl uut (
    .clk(clk), .rstN(rstN), .flashReq(flashReq), .flashAddr(flashAddr),
    .flashValid(flashValid), .flashRdata(flashRdata), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .dbgEnable(dbgEnable)
  );

  function automatic logic [31:0] expRead(logic en, logic match, logic rdy);
    return {29'b0, rdy, match, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic boot(logic [31:0] word, int delay, bit preWrites);
    @(negedge clk);
    rstN = 1'b0; flashValid = 1'b0; regWr = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 en", {31'b0, dbgEnable}, 32'h0);
    check("R1 req", {12'b0, flashReq, 19'b0} | {12'b0, flashAddr}, {12'b0, 1'b1, 19'b0} | {12'b0, ADDR});
    rstN = 1'b1;
    for (int i = 0; i < delay; i++) begin
      regWr = preWrites; regWdata = $urandom;
      @(negedge clk);
      check("R6 pre-ready write", regRdata, expRead(1'b0, 1'b0, 1'b0));
      check("R4 req held", {31'b0, flashReq}, 32'h1);
    end
    regWr = preWrites; regWdata = {31'b0, word == KEY};
    flashValid = 1'b1; flashRdata = word;
    @(negedge clk);
    flashValid = 1'b0; regWr = 1'b0;
    modelMatch = (word == KEY);
    modelEn = !modelMatch;
    check(modelMatch ? "R2 key match" : "R3 key mismatch", regRdata, expRead(modelEn, modelMatch, 1'b1));
    check("R4 req dropped", {31'b0, flashReq}, 32'h0);
  endtask

  task automatic doWrite(logic [31:0] data, logic strobe);
    regWr = strobe; regWdata = data;
    @(negedge clk);
    regWr = 1'b0;
    if (strobe) modelEn = data[0];
    check("R5 write", {31'b0, dbgEnable}, {31'b0, modelEn});
    check("R7 readback", regRdata, expRead(modelEn, modelMatch, 1'b1));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1263));
    boot(KEY, 0, 1'b0);                 // R2 immediate answer
    doWrite(32'h1, 1'b1);               // R5 unlock by software
    doWrite(32'hFFFF_FFFE, 1'b1);       // R5 lock via bit 0 only
    doWrite(32'h1, 1'b0);               // R5 no strobe, no change
    boot(KEY ^ 32'h0000_0001, 3, 1'b1); // R3 near-miss, R6 writes ignored
    boot(32'hFFFF_FFFF, 5, 1'b1);       // R3 erased flash
    boot(KEY, 4, 1'b1);                 // R6 with key
    // R8: stray flash pulses after decision
    flashValid = 1'b1; flashRdata = 32'h0;
    @(negedge clk);
    flashValid = 1'b0;
    check("R8 stray pulse", regRdata, expRead(modelEn, modelMatch, 1'b1));
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w;
      w = ($urandom % 2) ? KEY : $urandom;
      boot(w, $urandom % 6, 1'(($urandom % 2)));
      for (int k = 0; k < 6; k++) begin
        if ($urandom % 3 == 0) begin
          flashValid = 1'b1; flashRdata = KEY ^ {31'b0, modelMatch};
          @(negedge clk);
          flashValid = 1'b0;
          check("R8 stray pulse", regRdata, expRead(modelEn, modelMatch, 1'b1));
        end else begin
          doWrite($urandom, 1'(($urandom % 2)));
        end
        check("R9 gated by ready", {31'b0, dbgEnable & ~regRdata[2]}, 32'h0);
      end
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule